// File: doc/BRIEF.md
# Link Reset Handshake Controller

This block runs the low-level reset exchange of a serial radio link, one hyperframe at a time. A deframer hands it a single-cycle strobe at the start of each incoming hyperframe together with the reset bit recovered from that hyperframe. The block returns the reset bit that the framer places in the next outgoing hyperframe. Framing, the transceiver, link synchronization and the actual reset of the core lie outside this block.

The block works in one of two roles. As requester, it keeps sending the reset bit while the application holds its reset-assert input high and the enable bit is set. It stops once the far end's acknowledge has been seen in four consecutive hyperframes.

As acknowledger, it treats a request as real only after four consecutive hyperframes carry the bit. It then raises a live detect flag and a sticky detect-hold flag. When output-enable is set, it also raises a request line to the application. When the enable bit is set, it waits for the application's reset-assert before it acknowledges. The acknowledge is a run of exactly ten hyperframes with the bit set, and it is followed by live and sticky done flags.

Top module: `link_reset_hs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle after that edge. `tx_rst_bit`, `app_rst_req` and all four status flags are then 0.
- R2: In acknowledger mode (`cfg_master`=0), a request is detected only after `rx_rst_bit`=1 has been sampled on four consecutive strobes. A strobe with the bit at 0 restarts the count. Detection sets `st_detect` and `st_detect_hold` within two clock edges of the fourth strobe.
- R3: When a request is detected with `cfg_out_en`=1, `app_rst_req` goes high and stays high until `rst_n`. This holds even if `cfg_out_en` is cleared later. When `cfg_out_en`=0 at detection, `app_rst_req` stays low.
- R4: With `cfg_en`=1, no acknowledge bit is sent after detection until `app_rst_assert` is high. With `cfg_en`=0, the acknowledge starts without waiting for it.
- R5: The acknowledge drives `tx_rst_bit`=1 for exactly ten consecutive strobe intervals and then drives it back to 0.
- R6: On the strobe edge where `tx_rst_bit` returns to 0 after the ten-hyperframe run, `st_done` and `st_done_hold` are set.
- R7: `st_detect_hold` and `st_done_hold` stay set until a one-cycle pulse on `clr_detect_hold` or `clr_done_hold` clears them, one flag per pulse. The live flags `st_detect` and `st_done` clear when a new handshake starts: `st_done` clears on a new detection.
- R8: In requester mode (`cfg_master`=1), with `cfg_en`=1 and `app_rst_assert`=1, `tx_rst_bit` is 1 after the next strobe and stays 1 on the strobes that follow.
- R9: In requester mode, once `rx_rst_bit`=1 has been sampled on four consecutive strobes, `tx_rst_bit` drops to 0 at the next strobe. It stays 0 while `app_rst_assert` remains high.
- R10: In requester mode, clearing `cfg_en` (or dropping `app_rst_assert`) during a request drives `tx_rst_bit` to 0 at the next clock edge, without waiting for a strobe.
- R11: Apart from reset and the abort of R10, `tx_rst_bit` changes only on the clock edge that samples `hf_strobe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hf_strobe | input | 1 | One-cycle strobe at each hyperframe start |
| rx_rst_bit | input | 1 | Reset bit recovered from the incoming hyperframe |
| cfg_master | input | 1 | 1 = requester role, 0 = acknowledger role |
| cfg_en | input | 1 | Handshake enable; clearing it aborts a request |
| cfg_out_en | input | 1 | Allows the request line to the application |
| clr_detect_hold | input | 1 | Write-1-to-clear pulse for the detect-hold flag |
| clr_done_hold | input | 1 | Write-1-to-clear pulse for the done-hold flag |
| app_rst_assert | input | 1 | Application reset-assert |
| tx_rst_bit | output | 1 | Reset bit for the outgoing hyperframe |
| app_rst_req | output | 1 | Reset request to the application, held until reset |
| st_detect | output | 1 | Live request-detected flag |
| st_detect_hold | output | 1 | Sticky request-detected flag |
| st_done | output | 1 | Live acknowledge-complete flag |
| st_done_hold | output | 1 | Sticky acknowledge-complete flag |

## Verification
The hardest situation to reach is a detection run that breaks one hyperframe short and restarts. Once the request is finally confirmed, the ten-frame acknowledge must follow only after the application responds. The stimulus table walks through this one hyperframe at a time: two set bits, a clear bit, then four set bits. It holds reset-assert low for one extra frame and drops the incoming bit partway through the acknowledge. In a later pass it starts a second detection on top of the completed one, to show that the live done flag clears while the request line stays sticky.

// File: rtl/link_reset_hs_pkg.sv
// Package: shared types and default run lengths for the link reset handshake.
// Assumes: nothing beyond IEEE 1800-2017.
package link_reset_hs_pkg;

    localparam int DEF_DET_RUN = 4;
    localparam int DEF_ACK_RUN = 10;

    typedef enum logic [2:0] {
        HS_IDLE  = 3'd0,
        HS_REQ   = 3'd1,
        HS_MWAIT = 3'd2,
        HS_PEND  = 3'd3,
        HS_ACK   = 3'd4,
        HS_DONE  = 3'd5
    } hs_state_t;

endpackage

// File: rtl/lrh_run_detect.sv
// Module: counts consecutive strobes that sample the incoming bit set.
// Saturates at RUN; any strobe with the bit clear restarts from zero.
// Assumes: strobe is a single-cycle pulse; rst_n is synchronous, active low.
module lrh_run_detect #(
    parameter int RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic bit_in,
    output logic hit
);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN);

    logic [CW-1:0] run_q;

    // Advance, saturate or restart the run count on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (strobe) begin
            if (!bit_in)
                run_q <= '0;
            else if (run_q != FULL)
                run_q <= run_q + 1'b1;
        end
    end

    assign hit = (run_q == FULL);

endmodule

// File: rtl/lrh_burst_count.sv
// Module: counts strobes in an outgoing burst; flags when LEN have elapsed.
// Assumes: clear is held while no burst runs; step only pulses inside a burst.
module lrh_burst_count #(
    parameter int LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic at_end
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN);

    logic [CW-1:0] cnt_q;

    // Hold at zero outside a burst, count strobes inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (step && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign at_end = (cnt_q == LAST);

endmodule

// File: rtl/link_reset_hs.sv
// Module: link reset handshake controller, requester and acknowledger roles.
// The outgoing reset bit moves only on hyperframe strobes, except on abort.
// Assumes: cfg_master is static during a handshake; hf_strobe is one cycle wide.
module link_reset_hs
    import link_reset_hs_pkg::*;
#(
    parameter int DET_RUN = DEF_DET_RUN,
    parameter int ACK_RUN = DEF_ACK_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hf_strobe,
    input  logic rx_rst_bit,
    input  logic cfg_master,
    input  logic cfg_en,
    input  logic cfg_out_en,
    input  logic clr_detect_hold,
    input  logic clr_done_hold,
    input  logic app_rst_assert,
    output logic tx_rst_bit,
    output logic app_rst_req,
    output logic st_detect,
    output logic st_detect_hold,
    output logic st_done,
    output logic st_done_hold
);
    hs_state_t state_q;
    logic      run_hit;
    logic      burst_end;
    logic      burst_step;
    logic      burst_clear;
    logic      tx_q, req_q, det_q, det_hold_q, done_q, done_hold_q;

    lrh_run_detect #(.RUN(DET_RUN)) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (hf_strobe),
        .bit_in (rx_rst_bit),
        .hit    (run_hit)
    );

    assign burst_clear = (state_q != HS_ACK);
    assign burst_step  = (state_q == HS_ACK) && hf_strobe && !burst_end;

    lrh_burst_count #(.LEN(ACK_RUN)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (burst_clear),
        .step   (burst_step),
        .at_end (burst_end)
    );

    // Handshake sequencing, outgoing bit and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= HS_IDLE;
            tx_q        <= 1'b0;
            req_q       <= 1'b0;
            det_q       <= 1'b0;
            det_hold_q  <= 1'b0;
            done_q      <= 1'b0;
            done_hold_q <= 1'b0;
        end else begin
            if (clr_detect_hold) det_hold_q  <= 1'b0;
            if (clr_done_hold)   done_hold_q <= 1'b0;
            case (state_q)
                HS_IDLE: begin
                    if (cfg_master) begin
                        if (cfg_en && app_rst_assert) begin
                            state_q <= HS_REQ;
                            det_q   <= 1'b0;
                            done_q  <= 1'b0;
                        end
                    end else if (run_hit) begin
                        state_q    <= HS_PEND;
                        det_q      <= 1'b1;
                        det_hold_q <= 1'b1;
                        done_q     <= 1'b0;
                        if (cfg_out_en) req_q <= 1'b1;
                    end
                end
                HS_REQ: begin
                    if (!cfg_en || !app_rst_assert) begin
                        state_q <= HS_IDLE;
                        tx_q    <= 1'b0;
                    end else if (run_hit) begin
                        state_q <= HS_MWAIT;
                    end else if (hf_strobe) begin
                        tx_q <= 1'b1;
                    end
                end
                HS_MWAIT: begin
                    if (!cfg_en || !app_rst_assert) begin
                        state_q <= HS_IDLE;
                        tx_q    <= 1'b0;
                    end else if (hf_strobe) begin
                        tx_q <= 1'b0;
                    end
                end
                HS_PEND: begin
                    if (!cfg_en || app_rst_assert) state_q <= HS_ACK;
                end
                HS_ACK: begin
                    if (hf_strobe) begin
                        if (!burst_end) begin
                            tx_q <= 1'b1;
                        end else begin
                            tx_q        <= 1'b0;
                            done_q      <= 1'b1;
                            done_hold_q <= 1'b1;
                            state_q     <= HS_DONE;
                        end
                    end
                end
                HS_DONE: begin
                    if (!run_hit) state_q <= HS_IDLE;
                end
                default: state_q <= HS_IDLE;
            endcase
        end
    end

    assign tx_rst_bit     = tx_q;
    assign app_rst_req    = req_q;
    assign st_detect      = det_q;
    assign st_detect_hold = det_hold_q;
    assign st_done        = done_q;
    assign st_done_hold   = done_hold_q;

endmodule

// File: rtl/link_reset_hs_chk.sv
// Module: property checker for link_reset_hs, attached through bind.
// Assumes: observes top-level ports only; cfg_master static during a run.
module link_reset_hs_chk #(
    parameter int ACK_RUN = 10
) (
    input logic clk,
    input logic rst_n,
    input logic hf_strobe,
    input logic cfg_master,
    input logic cfg_en,
    input logic clr_detect_hold,
    input logic clr_done_hold,
    input logic app_rst_assert,
    input logic tx_rst_bit,
    input logic app_rst_req,
    input logic st_detect,
    input logic st_detect_hold,
    input logic st_done,
    input logic st_done_hold
);
    logic [7:0] ack_seen_q;

    // Track strobes sampling the outgoing bit high in acknowledger mode.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_master)
            ack_seen_q <= '0;
        else if (hf_strobe)
            ack_seen_q <= tx_rst_bit ? ((ack_seen_q == 8'hFF) ? ack_seen_q : ack_seen_q + 8'd1) : 8'd0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tx_rst_bit && !app_rst_req && !st_detect && !st_detect_hold && !st_done && !st_done_hold));

    a_r3_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        app_rst_req |=> app_rst_req);

    a_r5_ack_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen_q <= 8'(ACK_RUN));

    a_r6_done_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_done) |-> st_done_hold);

    a_r7_detect_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_detect_hold && !clr_detect_hold) |=> st_detect_hold);

    a_r7_done_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done_hold && !clr_done_hold) |=> st_done_hold);

    a_r10_abort_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !cfg_en) |=> !tx_rst_bit);

    a_r11_tx_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_rst_bit) |-> ($past(hf_strobe) || $past(!cfg_en) || $past(!app_rst_assert)));

    // Live detect only exists with its sticky copy unless software cleared it.
    a_r2_detect_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_detect) |-> st_detect_hold);

endmodule

bind link_reset_hs link_reset_hs_chk #(.ACK_RUN(ACK_RUN)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hf_strobe       (hf_strobe),
    .cfg_master      (cfg_master),
    .cfg_en          (cfg_en),
    .clr_detect_hold (clr_detect_hold),
    .clr_done_hold   (clr_done_hold),
    .app_rst_assert  (app_rst_assert),
    .tx_rst_bit      (tx_rst_bit),
    .app_rst_req     (app_rst_req),
    .st_detect       (st_detect),
    .st_detect_hold  (st_detect_hold),
    .st_done         (st_done),
    .st_done_hold    (st_done_hold)
);

// File: tb/test_link_reset_hs.sv
// Bench: vector table for one acknowledger handshake, then directed tests.
module test_link_reset_hs;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hf_strobe = 1'b0;
    logic rx_rst_bit = 1'b0;
    logic cfg_master = 1'b0;
    logic cfg_en = 1'b1;
    logic cfg_out_en = 1'b1;
    logic clr_detect_hold = 1'b0;
    logic clr_done_hold = 1'b0;
    logic app_rst_assert = 1'b0;
    logic tx_rst_bit, app_rst_req, st_detect, st_detect_hold, st_done, st_done_hold;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    link_reset_hs i_link_reset_hs (
        .clk             (clk),
        .rst_n           (rst_n),
        .hf_strobe       (hf_strobe),
        .rx_rst_bit      (rx_rst_bit),
        .cfg_master      (cfg_master),
        .cfg_en          (cfg_en),
        .cfg_out_en      (cfg_out_en),
        .clr_detect_hold (clr_detect_hold),
        .clr_done_hold   (clr_done_hold),
        .app_rst_assert  (app_rst_assert),
        .tx_rst_bit      (tx_rst_bit),
        .app_rst_req     (app_rst_req),
        .st_detect       (st_detect),
        .st_detect_hold  (st_detect_hold),
        .st_done         (st_done),
        .st_done_hold    (st_done_hold)
    );

    // Fields per hyperframe: {rx, assert, exp tx, exp req, exp detect, exp done}
    localparam logic [5:0] VEC [21] = '{
        6'b100000, 6'b100000, 6'b000000, 6'b100000, 6'b100000, 6'b100000,
        6'b100110, 6'b100110, 6'b110110, 6'b111110, 6'b111110,
        6'b011110, 6'b011110, 6'b011110, 6'b011110, 6'b011110,
        6'b011110, 6'b011110, 6'b011110, 6'b010111, 6'b010111
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hframe(input logic rx, input logic asrt);
        @(negedge clk);
        rx_rst_bit = rx;
        app_rst_assert = asrt;
        hf_strobe = 1'b1;
        @(negedge clk);
        hf_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        int ones;
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 tx", tx_rst_bit, 0);
        chk("R1 req", app_rst_req, 0);
        chk("R1 flags", {st_detect, st_detect_hold, st_done, st_done_hold}, 0);
        rst_n = 1'b1;

        // Table: acknowledger, enabled, output-enabled (R2 R3 R4 R5 R6)
        for (int i = 0; i < 21; i++) begin
            hframe(VEC[i][5], VEC[i][4]);
            chk($sformatf("R5 tx step %0d", i + 1), tx_rst_bit, VEC[i][3]);
            chk($sformatf("R3 req step %0d", i + 1), app_rst_req, VEC[i][2]);
            chk($sformatf("R2 detect step %0d", i + 1), st_detect, VEC[i][1]);
            chk($sformatf("R6 done step %0d", i + 1), st_done, VEC[i][0]);
        end
        chk("R6 done hold", st_done_hold, 1);
        chk("R2 detect hold", st_detect_hold, 1);

        // R7: write-1-to-clear, one flag per pulse
        @(negedge clk); clr_detect_hold = 1'b1;
        @(negedge clk); clr_detect_hold = 1'b0;
        chk("R7 detect hold cleared", st_detect_hold, 0);
        chk("R7 done hold kept", st_done_hold, 1);
        @(negedge clk); clr_done_hold = 1'b1;
        @(negedge clk); clr_done_hold = 1'b0;
        chk("R7 done hold cleared", st_done_hold, 0);

        // R3: request line stays high after output-enable is cleared
        cfg_out_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 req sticky", app_rst_req, 1);

        // R7: new detection clears live done
        for (int i = 0; i < 4; i++) hframe(1'b1, 1'b1);
        chk("R7 live done cleared", st_done, 0);
        chk("R7 detect again", st_detect, 1);

        // R1: reset clears the sticky request line too
        do_reset();
        chk("R1 req after reset", app_rst_req, 0);
        chk("R1 flags after reset", {st_detect, st_detect_hold, st_done, st_done_hold}, 0);

        // R3 R4 R5: disabled handshake acknowledges without the application
        cfg_en = 1'b0; cfg_out_en = 1'b0;
        for (int i = 0; i < 4; i++) hframe(1'b1, 1'b0);
        chk("R2 detect with enable off", st_detect, 1);
        chk("R3 req stays low", app_rst_req, 0);
        ones = 0;
        for (int i = 0; i < 12; i++) begin
            hframe(1'b0, 1'b0);
            if (tx_rst_bit) ones++;
        end
        chk("R5 ten ack frames", ones, 10);
        chk("R6 done after run", st_done, 1);

        // R8 R11: requester
        do_reset();
        cfg_master = 1'b1; cfg_en = 1'b1;
        @(negedge clk); app_rst_assert = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 no change without strobe", tx_rst_bit, 0);
        hframe(1'b0, 1'b1);
        chk("R8 request sent", tx_rst_bit, 1);
        hframe(1'b0, 1'b1);
        chk("R8 request held", tx_rst_bit, 1);

        // R9: acknowledge recognised after four frames
        for (int i = 0; i < 3; i++) hframe(1'b1, 1'b1);
        chk("R9 still requesting at three", tx_rst_bit, 1);
        hframe(1'b1, 1'b1);
        chk("R9 fourth frame edge", tx_rst_bit, 1);
        hframe(1'b1, 1'b1);
        chk("R9 request stopped", tx_rst_bit, 0);
        hframe(1'b0, 1'b1);
        chk("R9 stays stopped", tx_rst_bit, 0);

        // R10: abort by clearing enable
        do_reset();
        cfg_master = 1'b1; cfg_en = 1'b1;
        @(negedge clk); app_rst_assert = 1'b1;
        @(negedge clk);
        hframe(1'b0, 1'b1);
        chk("R10 request before abort", tx_rst_bit, 1);
        cfg_en = 1'b0;
        @(negedge clk);
        chk("R10 aborted without strobe", tx_rst_bit, 0);

        finish_run();
    end

endmodule